// File: doc/BRIEF.md
# Hierarchical Structural 16x16 Multiplier

This block multiplies two 16-bit unsigned operands and returns the full 32-bit product with no clock, no state and no latency. It does not infer the product from a multiply operator. The product is assembled from a hierarchy of smaller units.

A leaf unit multiplies two 4-bit values. It forms each partial-product bit with an AND gate and sums the rows through a rippling array of half and full adders, in the way multiplication is done by hand. Four leaves make an 8x8 unit, and four 8x8 units make the 16x16 top.

At each level the operands are split into high and low halves, and the four half-products are recombined. For a split width n, the result is the high-by-high product shifted left by 2n, plus both cross products shifted left by n, plus the low-by-low product.

The four 8x8 sub-products of the top are brought out as named wires so that the bound checker can observe them. A surrounding datapath uses the block as a single-cycle multiply stage.

Top module: `hmul16`

## Requirements
- R1: `product` equals the unsigned product of `op_a` and `op_b` for every operand pair, in full 32 bits with no truncation.
- R2: If either operand is zero, `product` is 32'h0000_0000.
- R3: With both operands 16'hFFFF, `product` is 32'hFFFE_0001.
- R4: With one operand equal to 16'h0001, `product` equals the other operand zero-extended to 32 bits.
- R5: If both operands have bits [7:0] clear, `product[15:0]` is zero and `product[31:16]` equals op_a[15:8] times op_b[15:8]. The high-by-high 8x8 sub-product alone carries this value.
- R6: If both operands are below 16, so that only one 4x4 leaf is active, `product` is below 256 and exact (for example 15x15 gives 225).
- R7: Swapping `op_a` and `op_b` does not change `product`.
- R8: The block is purely combinational: `product` reflects the operands present in the same cycle, with zero cycles of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | Multiplicand, unsigned |
| op_b | input | 16 | Multiplier, unsigned |
| product | output | 32 | Full unsigned product op_a x op_b |

## Verification
Every result is due in the same cycle as its operands because the block has no registers. The driver applies a pair of operands one time unit after a rising edge and pushes the expected product into the scoreboard queue at that time. The monitor pops and compares on the following falling edge, half a period later, in the same cycle. Each queued item thus matches exactly one operand pair, and the sample is taken after the adder array has settled and before the next pair arrives.

// File: rtl/hmul_pkg.sv
package hmul_pkg;

  localparam int OP_W    = 16;
  localparam int PROD_W  = 2 * OP_W;
  localparam int LEAF_W  = 4;
  localparam int QUADS   = 4;

  // Recombine four half-width products: hh<<2n + (lh+hl)<<n + ll
  function automatic logic [PROD_W-1:0] merge_quads(
    input logic [PROD_W-1:0] ll,
    input logic [PROD_W-1:0] lh,
    input logic [PROD_W-1:0] hl,
    input logic [PROD_W-1:0] hh,
    input int                n
  );
    return (hh << (2 * n)) + (lh << n) + (hl << n) + ll;
  endfunction

  // Shift-and-add reference, used only by the checker
  function automatic logic [PROD_W-1:0] ref_shift_add(
    input logic [OP_W-1:0] a,
    input logic [OP_W-1:0] b
  );
    logic [PROD_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < OP_W; i++) begin
      if (b[i]) acc = acc + ({{OP_W{1'b0}}, a} << i);
    end
    return acc;
  endfunction

endpackage

// File: rtl/mul_adder_bit.sv
module mul_adder_bit #(
  parameter bit HALF = 1'b0
) (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);

  if (HALF) begin : g_half
    logic unused_ci;
    assign unused_ci = ci;
    assign s  = x ^ y;
    assign co = x & y;
  end else begin : g_full
    logic xy;
    assign xy = x ^ y;
    assign s  = xy ^ ci;
    assign co = (x & y) | (xy & ci);
  end

endmodule

// File: rtl/mul_leaf.sv
module mul_leaf #(
  parameter int N = 4
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);

  for (genvar r = 0; r < N; r++) begin : row
    logic cout;
    for (genvar j = 0; j < N; j++) begin : col
      logic s;
      logic co;
      if (r == 0) begin : g_init
        assign s  = a[j] & b[0];
        assign co = 1'b0;
      end else begin : g_add
        logic x, y, ci;
        assign x = a[j] & b[r];
        if (j < N - 1) begin : g_y_sum
          assign y = row[r-1].col[j+1].s;
        end else begin : g_y_carry
          assign y = row[r-1].cout;
        end
        if (j == 0) begin : g_ci0
          assign ci = 1'b0;
        end else begin : g_cin
          assign ci = col[j-1].co;
        end
        mul_adder_bit #(.HALF(j == 0)) u_add (
          .x (x), .y (y), .ci (ci), .s (s), .co (co)
        );
      end
    end
    assign cout = col[N-1].co;
    assign p[r] = col[0].s;
  end

  for (genvar j = 1; j < N; j++) begin : g_hi
    assign p[N-1+j] = row[N-1].col[j].s;
  end
  assign p[2*N-1] = row[N-1].cout;

endmodule

// File: rtl/mul_quad8.sv
module mul_quad8
  import hmul_pkg::*;
(
  input  logic [2*LEAF_W-1:0] a,
  input  logic [2*LEAF_W-1:0] b,
  output logic [4*LEAF_W-1:0] p
);

  localparam int HW = LEAF_W;
  localparam int PW = 2 * LEAF_W;

  logic [PW-1:0] sub [QUADS];

  // quad index bit1 selects a half, bit0 selects b half
  for (genvar q = 0; q < QUADS; q++) begin : g_leaf
    logic [HW-1:0] ai, bi;
    assign ai = q[1] ? a[2*HW-1:HW] : a[HW-1:0];
    assign bi = q[0] ? b[2*HW-1:HW] : b[HW-1:0];
    mul_leaf #(.N(HW)) u_leaf (.a(ai), .b(bi), .p(sub[q]));
  end

  logic [PROD_W-1:0] merged;
  logic [PROD_W-4*HW-1:0] unused_hi;
  assign merged = merge_quads(PROD_W'(sub[0]), PROD_W'(sub[1]),
                              PROD_W'(sub[2]), PROD_W'(sub[3]), HW);
  assign {unused_hi, p} = merged;

endmodule

// File: rtl/hmul16.sv
module hmul16
  import hmul_pkg::*;
(
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  output logic [31:0] product
);

  localparam int HW = OP_W / 2;

  logic [OP_W-1:0] sub [QUADS];

  for (genvar q = 0; q < QUADS; q++) begin : g_unit
    logic [HW-1:0] ai, bi;
    assign ai = q[1] ? op_a[OP_W-1:HW] : op_a[HW-1:0];
    assign bi = q[0] ? op_b[OP_W-1:HW] : op_b[HW-1:0];
    mul_quad8 u_unit (.a(ai), .b(bi), .p(sub[q]));
  end

  // named sub-products for the checker
  logic [OP_W-1:0] prod_ll, prod_lh, prod_hl, prod_hh;
  assign prod_ll = sub[0];
  assign prod_lh = sub[1];
  assign prod_hl = sub[2];
  assign prod_hh = sub[3];

  assign product = merge_quads(PROD_W'(prod_ll), PROD_W'(prod_lh),
                               PROD_W'(prod_hl), PROD_W'(prod_hh), HW);

endmodule

// File: rtl/hmul16_chk.sv
module hmul16_chk
  import hmul_pkg::*;
(
  input logic [15:0] op_a,
  input logic [15:0] op_b,
  input logic [31:0] product,
  input logic [15:0] prod_hh,
  input logic [15:0] prod_ll
);

  always_comb begin
    a_r1_matches_ref: assert (product == ref_shift_add(op_a, op_b))
      else $error("R1 product mismatch");
    if (op_a == 16'h0 || op_b == 16'h0)
      a_r2_zero_operand: assert (product == 32'h0)
        else $error("R2 zero operand");
    if (op_a == 16'hFFFF && op_b == 16'hFFFF)
      a_r3_all_ones: assert (product == 32'hFFFE_0001)
        else $error("R3 all ones");
    if (op_b == 16'h1)
      a_r4_identity: assert (product == {16'h0, op_a})
        else $error("R4 identity");
    a_r5_hh_sub: assert (prod_hh == ref_shift_add({8'h0, op_a[15:8]},
                                                  {8'h0, op_b[15:8]})[15:0])
      else $error("R5 high quadrant");
    a_r6_ll_sub: assert (prod_ll == ref_shift_add({8'h0, op_a[7:0]},
                                                  {8'h0, op_b[7:0]})[15:0])
      else $error("R6 low quadrant");
  end

endmodule

bind hmul16 hmul16_chk u_chk (
  .op_a    (op_a),
  .op_b    (op_b),
  .product (product),
  .prod_hh (prod_hh),
  .prod_ll (prod_ll)
);

// File: tb/test_hmul16.sv
`timescale 1ns/1ps
module test_hmul16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic [31:0] product;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  hmul16 i_hmul16 (.op_a(op_a), .op_b(op_b), .product(product));

  function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b);
    longint unsigned m;
    m = longint'(a) * longint'(b);
    return m[31:0];
  endfunction

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input string req);
    item_t it;
    @(posedge clk);
    #1;
    op_a = a;
    op_b = b;
    it.exp = model(a, b);
    it.req = req;
    sb.push_back(it);
  endtask

  // monitor: results are due in the same cycle (R8), sampled at negedge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_checks++;
        if (product !== it.exp) begin
          n_fail++;
          $display("FAIL %s a=%h b=%h actual=%h expected=%h",
                   it.req, op_a, op_b, product, it.exp);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // reset state: operands held at zero -> R2
    @(negedge clk);
    n_checks++;
    if (product !== 32'h0) begin
      n_fail++;
      $display("FAIL R2 reset actual=%h expected=%h", product, 32'h0);
    end
    rst = 1'b0;

    drive(16'h0000, 16'h1234, "R2");
    drive(16'hBEEF, 16'h0000, "R2");
    drive(16'hFFFF, 16'hFFFF, "R3");
    drive(16'h0001, 16'hA5C3, "R4");
    drive(16'h7E01, 16'h0001, "R4");
    drive(16'h0001, 16'h0001, "R4");
    drive(16'hAB00, 16'hCD00, "R5");
    drive(16'hFF00, 16'hFF00, "R5");
    drive(16'h000F, 16'h000F, "R6");
    drive(16'h0009, 16'h0006, "R6");
    drive(16'h00FF, 16'h00FF, "R1");
    drive(16'h8000, 16'h8000, "R1");
    drive(16'hFFFF, 16'h0002, "R1");
    for (int i = 0; i < 300; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      drive(ra, rb, "R1");
      if (i < 40) drive(rb, ra, "R7");
    end
    // back-to-back changes, one per cycle -> R8
    for (int i = 0; i < 16; i++) begin
      drive(16'(i * 4099), 16'(16'hFFFF - i * 257), "R8");
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule